// File: doc/BRIEF.md
# Exception Admission Arbiter with Priority Masking

This block picks which pending exception the core may enter next. It takes a fixed non-maskable interrupt request, a fixed hard-fault request and a vector of programmable interrupt requests. Each programmable request has its own 8-bit priority value, and a lower value means a more urgent request. The block filters these requests through three mask registers that it holds internally. It then chooses the most urgent request that survives the masks. It raises a take strobe when that request is strictly more urgent than the level the core is running at.

The three masks are written through a small software port that has a select field. The first is a one-bit global mask that spares only the two fixed exceptions. The second is a one-bit fault mask that spares only the non-maskable interrupt. The third is an 8-bit threshold that is switched off by the value zero. The strobe and the chosen exception number are registered, so they reflect the inputs and mask state of the previous cycle.

Top module: `exc_mask_arb`

## Requirements
- R1: A pending non-maskable interrupt (level -2, number 2) is taken whatever the masks hold, provided the current level is above -2.
- R2: While the global mask is set, no programmable request is taken. The hard fault (level -1, number 3) and the non-maskable interrupt are still taken.
- R3: While the fault mask is set, the hard fault and all programmable requests are blocked, and only the non-maskable interrupt can be taken.
- R4: A threshold of zero masks nothing. A threshold n other than zero masks every programmable request whose priority value is n or more, and passes those below n.
- R5: Among the unmasked pending requests, the lowest level wins. A tie goes to the lowest exception number. Programmable request i has number 16+i, and its priority field is bits [8i+7:8i] of the priority bus.
- R6: The winner is taken only if its level is strictly below `cur_prio_i`. That input is a signed 10-bit value: -2 while servicing the non-maskable interrupt, -1 while servicing the hard fault, 0 to 255 in a handler, and 256 for no active exception. An equal level is not taken.
- R7: `take_o` and `exc_num_o` are registered and change one clock edge after their inputs. `exc_num_o` is zero whenever `take_o` is low, and reset clears both.
- R8: A mask write uses the following `mask_sel_i` codes: 0 writes the global mask from bit 0, 1 writes the fault mask from bit 0, 2 writes the whole threshold, and 3 changes nothing. The new value first affects the outputs two edges after the write is presented. Reset clears all three masks.
- R9: Clearing the global mask or the fault mask lets the requests it was blocking be taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pend_i | input | 1 | Non-maskable interrupt pending |
| hf_pend_i | input | 1 | Hard fault pending |
| irq_pend_i | input | NUM_IRQ | Programmable requests pending |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Priority value of each programmable request |
| cur_prio_i | input | PRIO_W+2 | Signed current execution level |
| mask_we_i | input | 1 | Mask write enable |
| mask_sel_i | input | 2 | Mask register select |
| mask_wdata_i | input | PRIO_W | Mask write data |
| take_o | output | 1 | Registered take strobe |
| exc_num_o | output | NUM_W | Registered number of the taken exception |

## Verification
Suppose a mask register holds the wrong value. The outputs then show the error one edge after a request pattern that the mask should block or pass: either a take appears where none is allowed, or an expected take is missing. A fault in the comparison logic shows up as the wrong exception number one edge after a tie or an equal-level pattern is applied. The bench therefore steps through mask settings and request patterns that lie on both sides of every boundary. It also checks the exact edge on which a mask write or an input change first becomes visible.

// File: rtl/exc_mask_pkg.sv
// Shared definitions for the exception admission arbiter.
// Assumes: levels are signed, with the two fixed exceptions at -2 and -1.
package exc_mask_pkg;
    typedef enum logic [1:0] {
        MSEL_GLOBAL = 2'd0,
        MSEL_FAULT  = 2'd1,
        MSEL_THRESH = 2'd2,
        MSEL_NONE   = 2'd3
    } mask_sel_e;

    localparam int NMI_LVL = -2;
    localparam int HF_LVL  = -1;
endpackage

// File: rtl/exc_mask_regs.sv
// Holds the three mask registers and applies software writes.
// Assumes: a write is presented for one cycle; select code 3 is a no-op.
module exc_mask_regs
    import exc_mask_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  mask_sel_e         sel_i,
    input  logic [PRIO_W-1:0] wdata_i,
    output logic              gmask_o,
    output logic              fmask_o,
    output logic [PRIO_W-1:0] thresh_o
);
    // Update the selected mask on a write; reset clears all masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask_o  <= 1'b0;
            fmask_o  <= 1'b0;
            thresh_o <= '0;
        end else if (we_i) begin
            case (sel_i)
                MSEL_GLOBAL: gmask_o  <= wdata_i[0];
                MSEL_FAULT:  fmask_o  <= wdata_i[0];
                MSEL_THRESH: thresh_o <= wdata_i;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/exc_mask_filter.sv
// Applies the masks to every request and gives each candidate a signed level.
// Candidate 0 is the non-maskable interrupt, 1 is the hard fault, and 2+i is
// programmable request i.
// Assumes: programmable priorities are unsigned and lower means more urgent.
module exc_mask_filter
    import exc_mask_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 8,
    localparam int LW     = PRIO_W + 2,
    localparam int NC     = NUM_IRQ + 2
) (
    input  logic                      nmi_pend_i,
    input  logic                      hf_pend_i,
    input  logic [NUM_IRQ-1:0]        irq_pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic                      gmask_i,
    input  logic                      fmask_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic [NC-1:0]             cand_vld_o,
    output logic [NC*LW-1:0]          cand_lvl_o
);
    // The fixed exceptions: only the fault mask can block the hard fault.
    assign cand_vld_o[0]      = nmi_pend_i;
    assign cand_lvl_o[0+:LW]  = LW'(NMI_LVL);
    assign cand_vld_o[1]      = hf_pend_i && !fmask_i;
    assign cand_lvl_o[LW+:LW] = LW'(HF_LVL);

    // One masking slice per programmable request.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        logic [PRIO_W-1:0] prio;
        logic              thr_hit;
        assign prio    = irq_prio_i[g*PRIO_W +: PRIO_W];
        assign thr_hit = (thresh_i != '0) && (prio >= thresh_i);
        assign cand_vld_o[g+2] = irq_pend_i[g] && !gmask_i && !fmask_i && !thr_hit;
        assign cand_lvl_o[(g+2)*LW +: LW] = {2'b00, prio};
    end
endmodule

// File: rtl/exc_prio_select.sv
// Finds the most urgent valid candidate, taking the lowest index on a tie, and
// decides whether it may preempt the current level.
// Assumes: candidate index order matches ascending exception number.
module exc_prio_select #(
    parameter int NC = 10,
    parameter int LW = 10,
    parameter int IW = 4
) (
    input  logic [NC-1:0]        cand_vld_i,
    input  logic [NC*LW-1:0]     cand_lvl_i,
    input  logic signed [LW-1:0] cur_lvl_i,
    output logic                 take_o,
    output logic [IW-1:0]        idx_o
);
    logic                 best_vld;
    logic signed [LW-1:0] best_lvl;
    logic signed [LW-1:0] lvl_c;
    logic [IW-1:0]        best_idx;

    // Linear scan; a strict compare keeps the earlier index on equal levels.
    always_comb begin
        best_vld = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        lvl_c    = '0;
        for (int i = 0; i < NC; i++) begin
            lvl_c = cand_lvl_i[i*LW +: LW];
            if (cand_vld_i[i] && (!best_vld || (lvl_c < best_lvl))) begin
                best_vld = 1'b1;
                best_lvl = lvl_c;
                best_idx = IW'(i);
            end
        end
    end

    // Preemption needs a strictly more urgent level than the running one.
    assign take_o = best_vld && (best_lvl < cur_lvl_i);
    assign idx_o  = best_idx;
endmodule

// File: rtl/exc_mask_arb.sv
// Top of the exception admission arbiter: mask registers, per-request
// filtering, winner selection and registered outputs.
// Assumes: cur_prio_i is a signed level (-2, -1, 0..2^PRIO_W), with the
// largest value meaning no active exception.
module exc_mask_arb
    import exc_mask_pkg::*;
#(
    parameter int NUM_IRQ  = 8,
    parameter int PRIO_W   = 8,
    parameter int NUM_W    = 8,
    parameter int NMI_NUM  = 2,
    parameter int HF_NUM   = 3,
    parameter int IRQ_BASE = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      nmi_pend_i,
    input  logic                      hf_pend_i,
    input  logic [NUM_IRQ-1:0]        irq_pend_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic signed [PRIO_W+1:0]  cur_prio_i,
    input  logic                      mask_we_i,
    input  logic [1:0]                mask_sel_i,
    input  logic [PRIO_W-1:0]         mask_wdata_i,
    output logic                      take_o,
    output logic [NUM_W-1:0]          exc_num_o
);
    localparam int LW = PRIO_W + 2;
    localparam int NC = NUM_IRQ + 2;
    localparam int IW = $clog2(NC);

    logic              gmask_q;
    logic              fmask_q;
    logic [PRIO_W-1:0] thresh_q;
    logic [NC-1:0]     cand_vld;
    logic [NC*LW-1:0]  cand_lvl;
    logic              take_c;
    logic [IW-1:0]     win_idx;
    logic [NUM_W-1:0]  num_c;

    exc_mask_regs #(.PRIO_W(PRIO_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (mask_we_i),
        .sel_i    (mask_sel_e'(mask_sel_i)),
        .wdata_i  (mask_wdata_i),
        .gmask_o  (gmask_q),
        .fmask_o  (fmask_q),
        .thresh_o (thresh_q)
    );

    exc_mask_filter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_filter (
        .nmi_pend_i (nmi_pend_i),
        .hf_pend_i  (hf_pend_i),
        .irq_pend_i (irq_pend_i),
        .irq_prio_i (irq_prio_i),
        .gmask_i    (gmask_q),
        .fmask_i    (fmask_q),
        .thresh_i   (thresh_q),
        .cand_vld_o (cand_vld),
        .cand_lvl_o (cand_lvl)
    );

    exc_prio_select #(.NC(NC), .LW(LW), .IW(IW)) u_sel (
        .cand_vld_i (cand_vld),
        .cand_lvl_i (cand_lvl),
        .cur_lvl_i  (cur_prio_i),
        .take_o     (take_c),
        .idx_o      (win_idx)
    );

    // Map the winning candidate index to its exception number.
    always_comb begin
        if (win_idx == '0) begin
            num_c = NUM_W'(NMI_NUM);
        end else if (win_idx == IW'(1)) begin
            num_c = NUM_W'(HF_NUM);
        end else begin
            num_c = NUM_W'(IRQ_BASE) + NUM_W'(win_idx) - NUM_W'(2);
        end
    end

    // Register the decision; the number reads zero when nothing is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            exc_num_o <= '0;
        end else begin
            take_o    <= take_c;
            exc_num_o <= take_c ? num_c : '0;
        end
    end
endmodule

// File: rtl/exc_mask_arb_chk.sv
// Temporal checks on the arbiter's ports and mask registers, bound into the top.
// Assumes: the default exception numbering of the top module.
module exc_mask_arb_chk #(
    parameter int LW       = 10,
    parameter int NUM_W    = 8,
    parameter int NMI_NUM  = 2,
    parameter int IRQ_BASE = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 nmi_pend,
    input logic signed [LW-1:0] cur_prio,
    input logic                 gmask,
    input logic                 fmask,
    input logic                 take,
    input logic [NUM_W-1:0]     exc_num
);
    assert_nmi_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && (cur_prio > -2)) |=> (take && (exc_num == NUM_W'(NMI_NUM))));

    assert_gmask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |=> !(take && (exc_num >= NUM_W'(IRQ_BASE))));

    assert_fmask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fmask |=> !(take && (exc_num != NUM_W'(NMI_NUM))));

    assert_no_preempt_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_prio == -2) |=> !take);

    assert_num_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (exc_num == '0));
endmodule

bind exc_mask_arb exc_mask_arb_chk #(
    .LW(PRIO_W + 2), .NUM_W(NUM_W), .NMI_NUM(NMI_NUM), .IRQ_BASE(IRQ_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_pend (nmi_pend_i),
    .cur_prio (cur_prio_i),
    .gmask    (gmask_q),
    .fmask    (fmask_q),
    .take     (take_o),
    .exc_num  (exc_num_o)
);

// File: tb/exc_mask_arb_tb.sv
// Vector-table bench for the exception admission arbiter, followed by directed
// tests of latency, ignored writes, mask release and reset.
module exc_mask_arb_tb;
    logic              clk = 1'b0;
    logic              rst_n;
    logic              nmi, hf;
    logic [7:0]        pend;
    logic [63:0]       prio;
    logic signed [9:0] cur;
    logic              we;
    logic [1:0]        sel;
    logic [7:0]        wdata;
    logic              take;
    logic [7:0]        num;
    int                total = 0;
    int                fails = 0;
    bit                done  = 1'b0;

    always #10 clk = ~clk;

    exc_mask_arb u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_pend_i(nmi), .hf_pend_i(hf),
        .irq_pend_i(pend), .irq_prio_i(prio), .cur_prio_i(cur),
        .mask_we_i(we), .mask_sel_i(sel), .mask_wdata_i(wdata),
        .take_o(take), .exc_num_o(num)
    );

    localparam logic [63:0] P0 = 64'h8070605040302010; // irq i -> 0x10*(i+1)
    localparam logic [63:0] P1 = 64'h3030303030303030; // all equal
    localparam logic [9:0]  CT = 10'h100, CH = 10'h3FF, CN = 10'h3FE;
    localparam logic [9:0]  C40 = 10'h040, C41 = 10'h041;
    localparam int NV = 19;
    // {gm, fm, thresh, nmi, hf, pend, prio, cur, exp_take, exp_num}
    localparam logic [102:0] VEC [NV] = '{
        {1'b0,1'b0,8'h00,1'b0,1'b0,8'h00,P0,CT,1'b0,8'h00}, // R7 nothing pending
        {1'b0,1'b0,8'h00,1'b0,1'b0,8'h08,P0,CT,1'b1,8'h13}, // R5 single
        {1'b0,1'b0,8'h00,1'b0,1'b0,8'hFF,P0,CT,1'b1,8'h10}, // R5 lowest value
        {1'b0,1'b0,8'h00,1'b0,1'b0,8'h6C,P1,CT,1'b1,8'h12}, // R5 tie
        {1'b0,1'b0,8'h00,1'b0,1'b1,8'h01,P0,CT,1'b1,8'h03}, // R5 hard fault first
        {1'b0,1'b0,8'h00,1'b1,1'b1,8'hFF,P0,CT,1'b1,8'h02}, // R1
        {1'b1,1'b0,8'h00,1'b0,1'b0,8'hFF,P0,CT,1'b0,8'h00}, // R2 blocked
        {1'b1,1'b0,8'h00,1'b0,1'b1,8'hFF,P0,CT,1'b1,8'h03}, // R2 hard fault passes
        {1'b1,1'b0,8'h00,1'b1,1'b0,8'hFF,P0,CT,1'b1,8'h02}, // R2 nmi passes
        {1'b0,1'b1,8'h00,1'b0,1'b1,8'hFF,P0,CT,1'b0,8'h00}, // R3 all blocked
        {1'b0,1'b1,8'h00,1'b1,1'b1,8'h00,P0,CT,1'b1,8'h02}, // R3 nmi passes
        {1'b0,1'b0,8'h40,1'b0,1'b0,8'hF8,P0,CT,1'b0,8'h00}, // R4 >= threshold
        {1'b0,1'b0,8'h41,1'b0,1'b0,8'hF8,P0,CT,1'b1,8'h13}, // R4 below threshold
        {1'b0,1'b0,8'h40,1'b0,1'b0,8'hFF,P0,CT,1'b1,8'h10}, // R4 low passes
        {1'b0,1'b0,8'h00,1'b0,1'b0,8'h08,P0,C40,1'b0,8'h00}, // R6 equal level
        {1'b0,1'b0,8'h00,1'b0,1'b0,8'h08,P0,C41,1'b1,8'h13}, // R6 strictly lower
        {1'b0,1'b0,8'h00,1'b0,1'b1,8'h00,P0,CH,1'b0,8'h00}, // R6 in hard fault
        {1'b0,1'b0,8'h00,1'b1,1'b1,8'h00,P0,CH,1'b1,8'h02}, // R1 nmi over fault
        {1'b0,1'b0,8'h00,1'b1,1'b0,8'h00,P0,CN,1'b0,8'h00}  // R6 in nmi
    };

    task automatic check(input string req, input logic te, input logic [7:0] ne);
        total++;
        if (take !== te || num !== ne) begin
            fails++;
            $display("FAIL %s: take=%0b num=%0h expected take=%0b num=%0h",
                     req, take, num, te, ne);
        end
    endtask

    task automatic write_mask(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R7: watchdog expired, actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; nmi = 1'b0; hf = 1'b0; pend = 8'hFF; prio = P0; cur = CT;
        we = 1'b0; sel = 2'd0; wdata = 8'h00;
        repeat (3) @(posedge clk);
        #1 check("R7 reset", 1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b1; pend = 8'h00;

        for (int v = 0; v < NV; v++) begin
            write_mask(2'd0, {7'd0, VEC[v][102]});
            write_mask(2'd1, {7'd0, VEC[v][101]});
            write_mask(2'd2, VEC[v][100:93]);
            nmi = VEC[v][92]; hf = VEC[v][91]; pend = VEC[v][90:83];
            prio = VEC[v][82:19]; cur = $signed(VEC[v][18:9]);
            @(posedge clk); #1;
            check($sformatf("vector %0d (R1..R7 table)", v), VEC[v][8], VEC[v][7:0]);
        end

        // R8: a global-mask write shows one edge late.
        write_mask(2'd0, 8'h00); write_mask(2'd1, 8'h00); write_mask(2'd2, 8'h00);
        nmi = 1'b0; hf = 1'b0; pend = 8'h01; prio = P0; cur = CT;
        @(posedge clk); #1 check("R8 baseline", 1'b1, 8'h10);
        @(negedge clk); we = 1'b1; sel = 2'd0; wdata = 8'h01;
        @(posedge clk); #1 check("R8 old mask still applies", 1'b1, 8'h10);
        @(negedge clk); we = 1'b0;
        @(posedge clk); #1 check("R8 new mask applies", 1'b0, 8'h00);

        // R9: clearing the global mask restores the request.
        write_mask(2'd0, 8'h00);
        @(posedge clk); #1 check("R9 global cleared", 1'b1, 8'h10);

        // R9: clearing the fault mask restores the hard fault.
        hf = 1'b1;
        write_mask(2'd1, 8'h01);
        @(posedge clk); #1 check("R3 fault mask blocks", 1'b0, 8'h00);
        write_mask(2'd1, 8'h00);
        @(posedge clk); #1 check("R9 fault cleared", 1'b1, 8'h03);
        hf = 1'b0;

        // R8: select code 3 changes no mask.
        write_mask(2'd3, 8'h01);
        @(posedge clk); #1 check("R8 select 3 ignored", 1'b1, 8'h10);

        // R7: an input change is not visible before the next edge.
        @(negedge clk); pend = 8'h00;
        #5 check("R7 before edge", 1'b1, 8'h10);
        @(posedge clk); #1 check("R7 after edge", 1'b0, 8'h00);

        // R8: reset clears a set mask and the outputs.
        write_mask(2'd0, 8'h01);
        pend = 8'h01;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 check("R7 reset clears outputs", 1'b0, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 check("R8 reset clears masks", 1'b1, 8'h10);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule